// File: doc/BRIEF.md
# Stereo Soft-Mute Gain Controller with Bit-Clock Watchdog

This block sits in the master-clock domain behind a serial audio receiver. On each sample strobe it scales a pair of signed PCM samples, left and right, by one shared gain.

An active-low mute input starts a linear fade to silence over a fixed number of sample periods. Loss of the bit clock also starts the fade, with no control input needed. The bit clock counts as lost when no edge indication arrives for a set number of master-clock cycles. Releasing the mute, or the return of bit-clock edges, restores full gain on the very next sample, with no ramp back up.

The gain is an unsigned value in which unity is 2^(GAIN_W-1). The output is the product of sample and gain divided by unity, rounded toward zero and clamped to the sample width. A status flag reports when the gain has reached zero.

Top module: `softmute_ctrl`

## Requirements
- R1: `mute_n` is active low and passes through a two-flop synchroniser. While it reads 1 and the bit clock is present, every output sample equals its input sample. While it reads 0, the fade runs.
- R2: Left and right are always scaled by the same gain value.
- R3: Unity gain is U = 2^(GAIN_W-1) and the step is S = floor(U/RAMP_STEPS). On the k-th muted strobe the gain becomes (RAMP_STEPS-k)*S. After RAMP_STEPS muted strobes it is exactly 0, and it stays 0 for further muted strobes.
- R4: On the first strobe after the mute request ends, the gain is unity again, including when a ramp is still in progress.
- R5: After LOSS_CYCLES master-clock cycles with `bclk_edge` low, the bit clock counts as lost and the fade runs even with `mute_n` high. The first `bclk_edge` pulse after that ends the loss condition.
- R6: Each output is trunc_toward_zero(in*gain/U), saturated to DATA_W bits. For example, -1 at any gain below U gives 0.
- R7: `muted` is 1 exactly when the current gain is 0. It updates in the same cycle as the outputs.
- R8: The outputs and `muted` update one clock after a `sample_strobe` cycle, and `out_valid` is high for that one cycle. Without a strobe, the outputs hold.
- R9: After reset, the outputs are 0, `out_valid` and `muted` are 0, the gain is unity and the bit clock counts as present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_edge | input | 1 | One-cycle pulse per synchronised bit-clock edge |
| sample_strobe | input | 1 | One-cycle pulse when a new sample pair is presented |
| mute_n | input | 1 | Asynchronous mute request, 0 = mute |
| in_l | input | DATA_W | Left input sample, two's complement |
| in_r | input | DATA_W | Right input sample, two's complement |
| out_l | output | DATA_W | Scaled left sample |
| out_r | output | DATA_W | Scaled right sample |
| out_valid | output | 1 | High for one cycle when outputs update |
| muted | output | 1 | High while gain is zero |

## Verification
The bench builds the block with DATA_W=16, GAIN_W=16, RAMP_STEPS=10 and LOSS_CYCLES=32. The short ramp brings the complete fade within reach in a few dozen strobes: the odd first step from unity down to 9*3276, the exact landing on zero and the hold at zero. The small loss window lets the bench stop the edge pulses and check the block both just inside and past the threshold. With 16-bit samples, the rounding of -1 and the full-scale negative value can be checked directly against a model that divides in wide integer arithmetic.

// File: rtl/softmute_pkg.sv
// Shared constants for the soft-mute controller.
// Assumes a stereo stream: channel 0 is left, channel 1 is right.
package softmute_pkg;
    localparam int NUM_CH = 2;
    localparam int CH_L   = 0;
    localparam int CH_R   = 1;

    // Unity gain code for a gain of the given width.
    function automatic int unity_code(input int gain_w);
        return 2 ** (gain_w - 1);
    endfunction
endpackage

// File: rtl/smc_mute_sync.sv
// Two-flop synchroniser for the asynchronous mute pin.
// Assumes the pin is quasi-static with respect to the sample rate.
// Resets to 1 (not muted).
module smc_mute_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic sync_n
);
    logic meta_q;
    logic sync_q;

    // Shift the pin level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= pin_n;
            sync_q <= meta_q;
        end
    end

    assign sync_n = sync_q;
endmodule

// File: rtl/smc_clk_monitor.sv
// Bit-clock watchdog: counts master-clock cycles since the last
// bit-clock edge pulse. When the count reaches LOSS_CYCLES, the clock
// is reported lost until the next edge pulse.
// Assumes edge pulses are already synchronised to clk.
module smc_clk_monitor #(
    parameter int LOSS_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_edge,
    output logic clk_lost
);
    localparam int CW = $clog2(LOSS_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LOSS_CYCLES);

    logic [CW-1:0] idle_cnt;

    // Clear on every edge, otherwise count up and saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (bclk_edge) begin
            idle_cnt <= '0;
        end else if (idle_cnt != LIMIT) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign clk_lost = (idle_cnt == LIMIT);
endmodule

// File: rtl/smc_gain_ramp.sv
// Shared gain register. While muting, each sample strobe lowers the
// gain by a fixed step, ending exactly at zero after RAMP_STEPS strobes.
// When not muting, the gain returns to unity at once.
// Unity is 2^(GAIN_W-1). The step is floor(unity/RAMP_STEPS), so the
// first step from unity also absorbs the division remainder.
module smc_gain_ramp #(
    parameter int GAIN_W     = 16,
    parameter int RAMP_STEPS = 800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_strobe,
    input  logic              mute_req,
    output logic [GAIN_W-1:0] gain,
    output logic [GAIN_W-1:0] gain_next
);
    localparam int ONE_I  = softmute_pkg::unity_code(GAIN_W);
    localparam int STEP_I = ONE_I / RAMP_STEPS;
    localparam int TOP_I  = STEP_I * RAMP_STEPS;
    localparam logic [GAIN_W-1:0] ONE  = GAIN_W'(ONE_I);
    localparam logic [GAIN_W-1:0] STEP = GAIN_W'(STEP_I);
    localparam logic [GAIN_W-1:0] TOP  = GAIN_W'(TOP_I);

    logic [GAIN_W-1:0] gain_q;

    // Select the gain that applies to the sample being strobed.
    always_comb begin
        if (!mute_req) begin
            gain_next = ONE;
        end else if (gain_q == ONE) begin
            gain_next = TOP - STEP;
        end else if (gain_q >= STEP) begin
            gain_next = gain_q - STEP;
        end else begin
            gain_next = '0;
        end
    end

    // Commit the new gain once per sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q <= ONE;
        end else if (sample_strobe) begin
            gain_q <= gain_next;
        end
    end

    assign gain = gain_q;
endmodule

// File: rtl/smc_scaler.sv
// Combinational multiply of one signed sample by an unsigned gain.
// The product is divided by 2^(GAIN_W-1), rounding toward zero, and
// then clamped to the DATA_W range.
module smc_scaler #(
    parameter int DATA_W = 24,
    parameter int GAIN_W = 16
) (
    input  logic signed [DATA_W-1:0] din,
    input  logic        [GAIN_W-1:0] gain,
    output logic signed [DATA_W-1:0] dout
);
    localparam int PROD_W = DATA_W + GAIN_W + 1;
    localparam int SHIFT  = GAIN_W - 1;
    localparam logic signed [PROD_W-1:0] BIAS =
        {{(PROD_W-SHIFT){1'b0}}, {SHIFT{1'b1}}};
    localparam logic signed [PROD_W-1:0] MAXV =
        {{(PROD_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [PROD_W-1:0] MINV =
        {{(PROD_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] biased;
    logic signed [PROD_W-1:0] scaled;

    // Multiply, bias negatives for truncation toward zero, shift and clamp.
    always_comb begin
        prod   = PROD_W'(din) * $signed({1'b0, gain});
        biased = prod[PROD_W-1] ? prod + BIAS : prod;
        scaled = biased >>> SHIFT;
        if (scaled > MAXV) begin
            dout = MAXV[DATA_W-1:0];
        end else if (scaled < MINV) begin
            dout = MINV[DATA_W-1:0];
        end else begin
            dout = scaled[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/softmute_ctrl.sv
// Stereo soft-mute controller. A mute request comes from the
// synchronised active-low mute pin or from the bit-clock watchdog. It
// fades both channels to zero over RAMP_STEPS sample strobes. With no
// request, full gain applies on the next strobe. Outputs are registered
// and update one clock after each strobe.
// Assumes bclk_edge and sample_strobe are one-cycle pulses in the clk domain.
module softmute_ctrl #(
    parameter int DATA_W      = 24,
    parameter int GAIN_W      = 16,
    parameter int RAMP_STEPS  = 800,
    parameter int LOSS_CYCLES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_edge,
    input  logic              sample_strobe,
    input  logic              mute_n,
    input  logic [DATA_W-1:0] in_l,
    input  logic [DATA_W-1:0] in_r,
    output logic [DATA_W-1:0] out_l,
    output logic [DATA_W-1:0] out_r,
    output logic              out_valid,
    output logic              muted
);
    import softmute_pkg::*;

    logic              mute_sync_n;
    logic              clk_lost;
    logic              mute_req;
    logic [GAIN_W-1:0] gain;
    logic [GAIN_W-1:0] gain_next;

    logic [DATA_W-1:0] ch_in  [NUM_CH];
    logic [DATA_W-1:0] ch_mul [NUM_CH];
    logic [DATA_W-1:0] ch_q   [NUM_CH];

    smc_mute_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n  (mute_n),
        .sync_n (mute_sync_n)
    );

    smc_clk_monitor #(.LOSS_CYCLES(LOSS_CYCLES)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_edge (bclk_edge),
        .clk_lost  (clk_lost)
    );

    assign mute_req = !mute_sync_n || clk_lost;

    smc_gain_ramp #(.GAIN_W(GAIN_W), .RAMP_STEPS(RAMP_STEPS)) u_ramp (
        .clk           (clk),
        .rst_n         (rst_n),
        .sample_strobe (sample_strobe),
        .mute_req      (mute_req),
        .gain          (gain),
        .gain_next     (gain_next)
    );

    assign ch_in[CH_L] = in_l;
    assign ch_in[CH_R] = in_r;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        smc_scaler #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_scale (
            .din  (ch_in[c]),
            .gain (gain_next),
            .dout (ch_mul[c])
        );

        // Capture the scaled sample of this channel on each strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_q[c] <= '0;
            end else if (sample_strobe) begin
                ch_q[c] <= ch_mul[c];
            end
        end
    end

    // Register the update pulse and the zero-gain status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            muted     <= 1'b0;
        end else begin
            out_valid <= sample_strobe;
            if (sample_strobe) begin
                muted <= (gain_next == '0);
            end
        end
    end

    assign out_l = ch_q[CH_L];
    assign out_r = ch_q[CH_R];
endmodule

// File: rtl/smc_checker.sv
// Assertion checker for softmute_ctrl, attached by bind.
module smc_checker #(
    parameter int GAIN_W = 16,
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bclk_edge,
    input logic              sample_strobe,
    input logic              mute_req,
    input logic              clk_lost,
    input logic [GAIN_W-1:0] gain,
    input logic              muted,
    input logic [DATA_W-1:0] out_l,
    input logic [DATA_W-1:0] out_r
);
    localparam logic [GAIN_W-1:0] ONE = GAIN_W'(softmute_pkg::unity_code(GAIN_W));

    assert_unmute_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_strobe && !mute_req) |=> (gain == ONE));

    assert_ramp_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_strobe && mute_req && gain != '0) |=> (gain < $past(gain)));

    assert_zero_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_req && gain == '0) |=> (gain == '0));

    assert_flag_tracks_gain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        muted == (gain == '0));

    assert_loss_needs_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_lost) |-> !$past(bclk_edge));

    assert_edge_restores_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_edge |=> !clk_lost);

    assert_hold_without_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_strobe |=> ($stable(out_l) && $stable(out_r) && $stable(muted)));
endmodule

bind softmute_ctrl smc_checker #(.GAIN_W(GAIN_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bclk_edge     (bclk_edge),
    .sample_strobe (sample_strobe),
    .mute_req      (mute_req),
    .clk_lost      (clk_lost),
    .gain          (gain),
    .muted         (muted),
    .out_l         (out_l),
    .out_r         (out_r)
);

// File: tb/tb_softmute_ctrl.sv
module tb_softmute_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 16;
    localparam int GW   = 16;
    localparam int NR   = 10;
    localparam int LOSS = 32;
    localparam int ONE  = 32768;
    localparam int STEP = ONE / NR;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bclk_edge = 1'b0;
    logic          sample_strobe = 1'b0;
    logic          mute_n = 1'b1;
    logic [DW-1:0] in_l = '0;
    logic [DW-1:0] in_r = '0;
    logic [DW-1:0] out_l;
    logic [DW-1:0] out_r;
    logic          out_valid;
    logic          muted;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;
    bit  bclk_run = 1;
    int  k_model = 0;
    bit  lost_model = 0;

    // vector: {mute_n, left, right}
    localparam logic [32:0] VECS [0:15] = '{
        {1'b1, 16'h7FFF, 16'h8000},
        {1'b1, 16'h1234, 16'hFFFF},
        {1'b1, 16'h0000, 16'hFFFB},
        {1'b1, 16'h8000, 16'h7FFF},
        {1'b0, 16'h7FFF, 16'h8000},
        {1'b0, 16'hFFFF, 16'h0001},
        {1'b0, 16'h03E8, 16'hFC18},
        {1'b0, 16'h4000, 16'hC000},
        {1'b0, 16'h7FFF, 16'h7FFF},
        {1'b0, 16'h8000, 16'h8000},
        {1'b0, 16'h0101, 16'hFEFF},
        {1'b0, 16'h5555, 16'hAAAA},
        {1'b0, 16'h7FFF, 16'h8000},
        {1'b0, 16'h7FFF, 16'h8000},
        {1'b1, 16'h2222, 16'hDDDE},
        {1'b1, 16'h8000, 16'h0007}
    };

    softmute_ctrl #(.DATA_W(DW), .GAIN_W(GW), .RAMP_STEPS(NR), .LOSS_CYCLES(LOSS)) dut (
        .clk(clk), .rst_n(rst_n), .bclk_edge(bclk_edge), .sample_strobe(sample_strobe),
        .mute_n(mute_n), .in_l(in_l), .in_r(in_r), .out_l(out_l), .out_r(out_r),
        .out_valid(out_valid), .muted(muted)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bit-clock edge pulses, one every four cycles while enabled.
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            bclk_edge = bclk_run;
            @(negedge clk);
            bclk_edge = 1'b0;
        end
    end

    function automatic int model_gain(input int k);
        return (k == 0) ? ONE : (NR - k) * STEP;
    endfunction

    function automatic int expect_out(input logic [DW-1:0] x, input int k);
        longint p;
        longint e;
        p = longint'($signed(x)) * longint'(model_gain(k));
        e = p / ONE;
        if (e > 32767) e = 32767;
        if (e < -32768) e = -32768;
        return int'(e);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic set_mute(input logic v);
        mute_n = v;
        repeat (3) @(negedge clk);
    endtask

    // One strobe; update the model; check both outputs, flag and pulse.
    task automatic strobe(input logic [DW-1:0] l, input logic [DW-1:0] r, input string tag);
        bit req;
        in_l = l;
        in_r = r;
        sample_strobe = 1'b1;
        @(negedge clk);
        sample_strobe = 1'b0;
        req = !mute_n || lost_model;
        if (!req) k_model = 0;
        else if (k_model < NR) k_model++;
        check({tag, " out_l"}, int'($signed(out_l)), expect_out(l, k_model));
        check({tag, " out_r"}, int'($signed(out_r)), expect_out(r, k_model));
        check({tag, " muted R7"}, int'(muted), int'(k_model == NR));
        check({tag, " out_valid R8"}, int'(out_valid), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        logic [DW-1:0] hl;
        // R9: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset out_l", int'(out_l), 0);
        check("R9 reset out_r", int'(out_r), 0);
        check("R9 reset muted", int'(muted), 0);
        check("R9 reset out_valid", int'(out_valid), 0);

        // R1 R2 R3 R6 R4: table walk
        for (int i = 0; i < 16; i++) begin
            if (VECS[i][32] != mute_n) set_mute(VECS[i][32]);
            strobe(VECS[i][31:16], VECS[i][15:0], $sformatf("R1/R3/R6 vec%0d", i));
        end

        // R8: outputs hold without a strobe
        hl = out_l;
        in_l = 16'h1111;
        repeat (4) @(negedge clk);
        check("R8 hold out_l", int'(out_l), int'(hl));
        check("R8 valid low", int'(out_valid), 0);

        // R4: release partway through a ramp
        set_mute(1'b0);
        for (int i = 0; i < 3; i++) strobe(16'h4000, 16'hC000, "R4 ramp");
        set_mute(1'b1);
        strobe(16'h4000, 16'hC000, "R4 release");
        check("R4 full gain", int'(out_l), 16'h4000);

        // R3: zero is reached and held
        set_mute(1'b0);
        for (int i = 0; i < NR + 3; i++) strobe(16'h7FFF, 16'h8000, "R3 ramp");
        check("R3 zero held", int'(out_l), 0);
        set_mute(1'b1);
        strobe(16'h7FFF, 16'h8000, "R4 from zero");

        // R5: just inside the loss window there is no mute
        @(negedge clk);
        bclk_run = 0;
        repeat (8) @(negedge clk);
        strobe(16'h3000, 16'hD000, "R5 inside window");
        check("R5 inside full", int'(out_l), 16'h3000);
        repeat (40) @(negedge clk);
        lost_model = 1;
        for (int i = 0; i < 2; i++) strobe(16'h3000, 16'hD000, "R5 lost");
        check("R5 lost fade", int'(out_l), expect_out(16'h3000, 2));
        bclk_run = 1;
        repeat (6) @(negedge clk);
        lost_model = 0;
        strobe(16'h3000, 16'hD000, "R5 restored");
        check("R5 restored full", int'(out_l), 16'h3000);

        // R9: reset during a mute returns to unity
        set_mute(1'b0);
        for (int i = 0; i < NR; i++) strobe(16'h1000, 16'h1000, "R9 pre");
        set_mute(1'b1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 muted cleared", int'(muted), 0);
        check("R9 out cleared", int'(out_l), 0);
        k_model = 0;
        strobe(16'h1000, 16'h1000, "R9 post");

        summary();
    end
endmodule